// File: doc/BRIEF.md
# Bridge Error Interrupt Status Register

This block holds the error-interrupt status of the PCI side of an address translation unit. Single-cycle event pulses from the bus logic set sticky bits. Five of these bits are also copied into a companion status register, and the two copies are cleared on separate paths. A registered, active-low interrupt request is driven while any bit of a chosen subset is set.

The local processor reads the register and clears bits by writing ones. The write port has byte enables. The configuration-space port sees the same bit values, but it cannot change them. A read data parity error that occurs while a separate DMA master owns the bus does not set the parity bit. That event goes out on its own DMA error output instead.

Top module: `errIrqStatus`

## Requirements
- R1: The register is 32 bits wide. Bits 31:11, bit 8 and bits 6:5 are reserved. They always read as 0, and writing ones to them has no effect.
- R2: After reset every bit reads 0 and `irqN` is 1. An event pulse in a cycle sets its bit at that clock edge, and the bit stays set until it is cleared.
- R3: A processor write (cpuValid=1, cpuWrite=1) clears each implemented bit whose data bit is 1, but only if the byte lane of that bit is enabled (bits 7:0 use cpuByteEn[0], bits 10:8 use cpuByteEn[1]). Data bits that are 0 leave their bits unchanged.
- R4: Event to bit mapping: target abort as target sets bit 1, target abort as master sets bit 2, master abort sets bit 3, SERR seen on the bus sets bit 4, SERR driven by the unit sets bit 10, parity report sets bit 0, internal-bus master abort sets bit 7.
- R5: Bit 9 (detected parity) is set by a write data parity error as target, by a read data parity error as master, and by any address parity error.
- R6: A read data parity error while `dmaOwnsBus`=1 leaves bit 9 unchanged and raises `dmaParErr` in the same cycle.
- R7: `compBits[4:0]` is the companion copy of status bits 4:0, standing for companion bits 14, 13, 12, 11 and 8. Both copies are set at the same edge. `compClear` clears only the companion copy, and a processor clear clears only the status copy.
- R8: `irqN` is 0 exactly one cycle after any of bits 4:0, 7 or 9 is set, and it returns to 1 one cycle after the last of them is cleared. Bit 10 never drives `irqN`.
- R9: A configuration read returns the same 32-bit value a processor read would return. A configuration write changes no bit.
- R10: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R11: A processor or configuration read returns, with its valid flag, in the next cycle the register value as it was at the request edge. The valid flag is 0 when no read was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtTgtAbtAsTgt | input | 1 | Unit ended a transaction as target with target abort |
| evtTgtAbtAsMst | input | 1 | Transaction the unit initiated received a target abort |
| evtMstAbt | input | 1 | Transaction the unit initiated ended in master abort |
| evtSerrSeen | input | 1 | SERR observed on the bus |
| evtSerrDriven | input | 1 | Unit asserted SERR |
| evtParReport | input | 1 | Parity-related report event (bit 0) |
| evtIntMstAbt | input | 1 | Internal-bus master transaction ended in master abort |
| evtWrParTgt | input | 1 | Write data parity error, unit as target |
| evtRdParMst | input | 1 | Read data parity error, bus master read |
| evtAddrPar | input | 1 | Address parity error on the bus |
| dmaOwnsBus | input | 1 | The DMA master, not the unit, owns the current read |
| dmaParErr | output | 1 | Read parity error routed to the DMA error path |
| compBits | output | 5 | Companion copy of status bits 4:0 |
| compClear | input | 5 | Clear strobes for the companion copy |
| cpuValid | input | 1 | Processor access request |
| cpuWrite | input | 1 | 1 = write-1-to-clear, 0 = read |
| cpuByteEn | input | 4 | Write byte enables |
| cpuWdata | input | 32 | Write data |
| cpuRdata | output | 32 | Processor read data |
| cpuRvalid | output | 1 | Processor read data valid |
| cfgValid | input | 1 | Configuration access request |
| cfgWrite | input | 1 | Configuration write (has no effect) |
| cfgRdata | output | 32 | Configuration read data |
| cfgRvalid | output | 1 | Configuration read data valid |
| irqN | output | 1 | Registered active-low interrupt request |

## Verification
Each event is pulsed on its own and then cleared, which tells apart the bit each source lands in and whether that bit reaches the interrupt. The three parity sources are tried with and without DMA bus ownership, which separates the detected-parity bit from the DMA error path. Clearing writes use mixed data and byte-enable patterns, a write that lands in the same cycle as an event, and clears sent only down the companion path. These show that each copy, each byte lane and the set-over-clear rule act independently. Configuration writes made between processor reads show that the read-only view leaves the state alone.

// File: rtl/errIrqPkg.sv
package errIrqPkg;
  localparam int STAT_W = 11;
  localparam int MIR_W  = 5;
  // implemented bits: 10, 9, 7, 4..0
  localparam logic [STAT_W-1:0] IMPL_MASK = 11'b110_1001_1111;
  // interrupt sources: 9, 7, 4..0
  localparam logic [STAT_W-1:0] IRQ_MASK  = 11'b010_1001_1111;

  localparam int B_PAR_RPT   = 0;
  localparam int B_TA_TGT    = 1;
  localparam int B_TA_MST    = 2;
  localparam int B_MST_ABT   = 3;
  localparam int B_SERR_SEEN = 4;
  localparam int B_INT_MA    = 7;
  localparam int B_PAR_DET   = 9;
  localparam int B_SERR_DRV  = 10;

  typedef struct packed {
    logic [STAT_W-1:0] clrMask;
    logic              cpuRd;
    logic              cfgRd;
  } strobeT;
endpackage

// File: rtl/errIrqCtrl.sv
module errIrqCtrl
  import errIrqPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [DATA_W/8-1:0] cpuByteEn,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              cfgValid,
  input  logic              cfgWrite,
  output strobeT            strb
);
  localparam int BE_W    = DATA_W / 8;
  localparam int USED_BE = (STAT_W + 7) / 8;

  logic              wrEn;
  logic [STAT_W-1:0] laneClr;
  logic              unusedHiBits;

  assign wrEn = cpuValid & cpuWrite;

  for (genvar b = 0; b < STAT_W; b++) begin : g_lane
    if (IMPL_MASK[b]) begin : g_impl
      assign laneClr[b] = cpuWdata[b] & cpuByteEn[b/8];
    end else begin : g_rsvd
      assign laneClr[b] = 1'b0;
    end
  end

  // upper data bits and byte lanes carry only reserved fields
  assign unusedHiBits = ^{cpuWdata[DATA_W-1:STAT_W], cpuByteEn[BE_W-1:USED_BE]};

  always_comb begin
    strb.clrMask = wrEn ? laneClr : '0;
    strb.cpuRd   = cpuValid & ~cpuWrite;
    strb.cfgRd   = cfgValid & ~cfgWrite;
  end
endmodule

// File: rtl/errIrqData.sv
module errIrqData
  import errIrqPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtTgtAbtAsTgt,
  input  logic              evtTgtAbtAsMst,
  input  logic              evtMstAbt,
  input  logic              evtSerrSeen,
  input  logic              evtSerrDriven,
  input  logic              evtParReport,
  input  logic              evtIntMstAbt,
  input  logic              evtWrParTgt,
  input  logic              evtRdParMst,
  input  logic              evtAddrPar,
  input  logic              dmaOwnsBus,
  input  logic [MIR_W-1:0]  compClear,
  input  strobeT            strb,
  output logic [STAT_W-1:0] statVec,
  output logic [MIR_W-1:0]  compBits,
  output logic              dmaParErr,
  output logic              irqN,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuRvalid,
  output logic [DATA_W-1:0] cfgRdata,
  output logic              cfgRvalid
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic [STAT_W-1:0] setVec;
  logic [STAT_W-1:0] nextStat;
  logic [MIR_W-1:0]  nextComp;
  logic [DATA_W-1:0] rdView;
  logic              unitRdPar;

  assign unitRdPar = evtRdParMst & ~dmaOwnsBus;
  assign dmaParErr = evtRdParMst & dmaOwnsBus;

  always_comb begin
    setVec              = '0;
    setVec[B_PAR_RPT]   = evtParReport;
    setVec[B_TA_TGT]    = evtTgtAbtAsTgt;
    setVec[B_TA_MST]    = evtTgtAbtAsMst;
    setVec[B_MST_ABT]   = evtMstAbt;
    setVec[B_SERR_SEEN] = evtSerrSeen;
    setVec[B_INT_MA]    = evtIntMstAbt;
    setVec[B_PAR_DET]   = evtWrParTgt | unitRdPar | evtAddrPar;
    setVec[B_SERR_DRV]  = evtSerrDriven;
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      // a set in the same cycle overrides a clear
      assign nextStat[b] = setVec[b] | (statVec[b] & ~strb.clrMask[b]);
    end else begin : g_rsvd
      assign nextStat[b] = 1'b0;
    end
  end

  for (genvar m = 0; m < MIR_W; m++) begin : g_mir
    assign nextComp[m] = setVec[m] | (compBits[m] & ~compClear[m]);
  end

  assign rdView = {{PAD_W{1'b0}}, statVec};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statVec   <= '0;
      compBits  <= '0;
      irqN      <= 1'b1;
      cpuRdata  <= '0;
      cpuRvalid <= 1'b0;
      cfgRdata  <= '0;
      cfgRvalid <= 1'b0;
    end else begin
      statVec   <= nextStat;
      compBits  <= nextComp;
      irqN      <= ~|(statVec & IRQ_MASK);
      cpuRvalid <= strb.cpuRd;
      cfgRvalid <= strb.cfgRd;
      if (strb.cpuRd) cpuRdata <= rdView;
      if (strb.cfgRd) cfgRdata <= rdView;
    end
  end
endmodule

// File: rtl/errIrqStatus.sv
module errIrqStatus
  import errIrqPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtTgtAbtAsTgt,
  input  logic              evtTgtAbtAsMst,
  input  logic              evtMstAbt,
  input  logic              evtSerrSeen,
  input  logic              evtSerrDriven,
  input  logic              evtParReport,
  input  logic              evtIntMstAbt,
  input  logic              evtWrParTgt,
  input  logic              evtRdParMst,
  input  logic              evtAddrPar,
  input  logic              dmaOwnsBus,
  output logic              dmaParErr,
  output logic [4:0]        compBits,
  input  logic [4:0]        compClear,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [DATA_W/8-1:0] cpuByteEn,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuRvalid,
  input  logic              cfgValid,
  input  logic              cfgWrite,
  output logic [DATA_W-1:0] cfgRdata,
  output logic              cfgRvalid,
  output logic              irqN
);
  strobeT            strb;
  logic [STAT_W-1:0] statVec;

  errIrqCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .cpuValid (cpuValid),
    .cpuWrite (cpuWrite),
    .cpuByteEn(cpuByteEn),
    .cpuWdata (cpuWdata),
    .cfgValid (cfgValid),
    .cfgWrite (cfgWrite),
    .strb     (strb)
  );

  errIrqData #(.DATA_W(DATA_W)) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .evtTgtAbtAsTgt(evtTgtAbtAsTgt),
    .evtTgtAbtAsMst(evtTgtAbtAsMst),
    .evtMstAbt     (evtMstAbt),
    .evtSerrSeen   (evtSerrSeen),
    .evtSerrDriven (evtSerrDriven),
    .evtParReport  (evtParReport),
    .evtIntMstAbt  (evtIntMstAbt),
    .evtWrParTgt   (evtWrParTgt),
    .evtRdParMst   (evtRdParMst),
    .evtAddrPar    (evtAddrPar),
    .dmaOwnsBus    (dmaOwnsBus),
    .compClear     (compClear),
    .strb          (strb),
    .statVec       (statVec),
    .compBits      (compBits),
    .dmaParErr     (dmaParErr),
    .irqN          (irqN),
    .cpuRdata      (cpuRdata),
    .cpuRvalid     (cpuRvalid),
    .cfgRdata      (cfgRdata),
    .cfgRvalid     (cfgRvalid)
  );
endmodule

// File: rtl/errIrqChk.sv
module errIrqChk
  import errIrqPkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              evtSerrDriven,
  input logic              evtParReport,
  input logic              evtIntMstAbt,
  input logic              evtWrParTgt,
  input logic              evtRdParMst,
  input logic              evtAddrPar,
  input logic              dmaOwnsBus,
  input logic              dmaParErr,
  input logic              cpuValid,
  input logic              cpuWrite,
  input logic [DATA_W/8-1:0] cpuByteEn,
  input logic [DATA_W-1:0] cpuWdata,
  input logic [STAT_W-1:0] statVec,
  input logic [DATA_W-1:0] cpuRdata,
  input logic              cpuRvalid,
  input logic [DATA_W-1:0] cfgRdata,
  input logic              cfgRvalid,
  input logic              irqN
);
  // R1: reserved fields of returned data are zero
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    cpuRvalid |-> (cpuRdata[DATA_W-1:11] == '0 && cpuRdata[8] == 1'b0 && cpuRdata[6:5] == 2'b00));

  // R4: SERR driven by the unit lands in bit 10
  p_serr_drv_r4: assert property (@(posedge clk) disable iff (!rstN)
    evtSerrDriven |=> statVec[B_SERR_DRV]);

  // R2: bit 7 stays set unless cleared through its enabled lane
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (statVec[B_INT_MA] && !(cpuValid && cpuWrite && cpuByteEn[0] && cpuWdata[B_INT_MA]))
      |=> statVec[B_INT_MA]);

  // R10: event wins over a same-cycle clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    evtParReport |=> statVec[B_PAR_RPT]);

  // R6: DMA-owned read parity leaves bit 9 alone and is flagged
  p_dma_route_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dmaOwnsBus && evtRdParMst && !evtWrParTgt && !evtAddrPar && !statVec[B_PAR_DET])
      |=> !statVec[B_PAR_DET]);

  p_dma_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dmaOwnsBus && evtRdParMst) |-> dmaParErr);

  // R8: interrupt follows the masked status one cycle later
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqN == ~|($past(statVec) & IRQ_MASK)));

  // R9: configuration view returns the status at request time
  p_cfg_view_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgRvalid |-> (cfgRdata[STAT_W-1:0] == $past(statVec)));

  // R5: internal master abort is not a parity source
  p_int_ma_r5: assert property (@(posedge clk) disable iff (!rstN)
    (evtIntMstAbt && !evtWrParTgt && !evtAddrPar && !evtRdParMst && !statVec[B_PAR_DET])
      |=> !statVec[B_PAR_DET]);
endmodule

bind errIrqStatus errIrqChk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .evtSerrDriven(evtSerrDriven),
  .evtParReport (evtParReport),
  .evtIntMstAbt (evtIntMstAbt),
  .evtWrParTgt  (evtWrParTgt),
  .evtRdParMst  (evtRdParMst),
  .evtAddrPar   (evtAddrPar),
  .dmaOwnsBus   (dmaOwnsBus),
  .dmaParErr    (dmaParErr),
  .cpuValid     (cpuValid),
  .cpuWrite     (cpuWrite),
  .cpuByteEn    (cpuByteEn),
  .cpuWdata     (cpuWdata),
  .statVec      (statVec),
  .cpuRdata     (cpuRdata),
  .cpuRvalid    (cpuRvalid),
  .cfgRdata     (cfgRdata),
  .cfgRvalid    (cfgRvalid),
  .irqN         (irqN)
);

// File: tb/test_errIrqStatus.sv
module test_errIrqStatus;
  localparam int DW = 32;
  localparam logic [10:0] IMPL = 11'b110_1001_1111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] ev = '0;
  logic dmaOwn = 1'b0;
  logic [4:0] compClr = '0;
  logic cpuValid = 1'b0, cpuWrite = 1'b0, cfgValid = 1'b0, cfgWrite = 1'b0;
  logic [3:0] cpuBe = '0;
  logic [DW-1:0] cpuWd = '0;
  logic dmaParErr, cpuRvalid, cfgRvalid, irqN;
  logic [4:0] compBits;
  logic [DW-1:0] cpuRdata, cfgRdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [10:0] mdl = '0;
  logic [4:0] mdlComp = '0;
  logic [DW-1:0] cpuQ[$];
  string cpuTagQ[$];
  logic [DW-1:0] cfgQ[$];
  string cfgTagQ[$];

  always #10 clk = ~clk;

  errIrqStatus #(.DATA_W(DW)) i_errIrqStatus (
    .clk(clk), .rstN(rstN),
    .evtTgtAbtAsTgt(ev[0]), .evtTgtAbtAsMst(ev[1]), .evtMstAbt(ev[2]),
    .evtSerrSeen(ev[3]), .evtSerrDriven(ev[4]), .evtParReport(ev[5]),
    .evtIntMstAbt(ev[6]), .evtWrParTgt(ev[7]), .evtRdParMst(ev[8]),
    .evtAddrPar(ev[9]), .dmaOwnsBus(dmaOwn), .dmaParErr(dmaParErr),
    .compBits(compBits), .compClear(compClr),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuByteEn(cpuBe), .cpuWdata(cpuWd),
    .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid),
    .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgRdata(cfgRdata), .cfgRvalid(cfgRvalid),
    .irqN(irqN)
  );

  function automatic int bitOf(input int i);
    case (i)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;
      4: return 10; 5: return 0;  6: return 7;  default: return 9;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rstN && cpuRvalid) begin
      if (cpuQ.size() == 0) chk(1'b0, "R11 unexpected cpu read", cpuRdata, '0);
      else begin
        logic [DW-1:0] e; string t;
        e = cpuQ.pop_front(); t = cpuTagQ.pop_front();
        chk(cpuRdata == e, t, cpuRdata, e);
      end
    end
    if (rstN && cfgRvalid) begin
      if (cfgQ.size() == 0) chk(1'b0, "R11 unexpected cfg read", cfgRdata, '0);
      else begin
        logic [DW-1:0] e; string t;
        e = cfgQ.pop_front(); t = cfgTagQ.pop_front();
        chk(cfgRdata == e, t, cfgRdata, e);
      end
    end
  end

  // one cycle, started and ended at a falling edge
  task automatic drive(input logic [9:0] evIn, input logic dma, input logic [4:0] cclr,
                       input logic wr, input logic [3:0] be, input logic [DW-1:0] wd,
                       input logic rd, input logic cfgRd, input logic cfgWr, input string tag);
    logic [10:0] setM, clrM;
    ev = evIn; dmaOwn = dma; compClr = cclr;
    cpuValid = wr | rd; cpuWrite = wr; cpuBe = be; cpuWd = wd;
    cfgValid = cfgRd | cfgWr; cfgWrite = cfgWr;
    if (rd) begin cpuQ.push_back({21'd0, mdl}); cpuTagQ.push_back(tag); end
    if (cfgRd) begin cfgQ.push_back({21'd0, mdl}); cfgTagQ.push_back(tag); end
    setM = '0;
    for (int i = 0; i < 10; i++)
      if (evIn[i] && !(i == 8 && dma)) setM[bitOf(i)] = 1'b1;
    clrM = '0;
    if (wr) for (int b = 0; b < 11; b++) clrM[b] = wd[b] & be[b/8] & IMPL[b];
    #2;
    if (evIn[8]) chk(dmaParErr == dma, "R6 dma error flag", {31'd0, dmaParErr}, {31'd0, dma});
    @(posedge clk);
    mdl = setM | (mdl & ~clrM);
    mdlComp = setM[4:0] | (mdlComp & ~cclr);
    @(negedge clk);
    ev = '0; dmaOwn = 1'b0; compClr = '0; cpuValid = 1'b0; cpuWrite = 1'b0;
    cpuBe = '0; cpuWd = '0; cfgValid = 1'b0; cfgWrite = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] v, input logic dma);
    drive(v, dma, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, "");
  endtask
  task automatic rdBoth(input string tag);
    drive('0, 1'b0, '0, 1'b0, '0, '0, 1'b1, 1'b1, 1'b0, tag);
  endtask
  task automatic wr1c(input logic [3:0] be, input logic [DW-1:0] wd);
    drive('0, 1'b0, '0, 1'b1, be, wd, 1'b0, 1'b0, 1'b0, "");
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive('0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, "");
  endtask
  task automatic clearAll();
    drive('0, 1'b0, 5'h1f, 1'b1, 4'hf, '1, 1'b0, 1'b0, 1'b0, "");
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: reset state
    chk(irqN == 1'b1, "R2 reset irqN", {31'd0, irqN}, 32'd1);
    chk(compBits == 5'd0, "R2 reset companion", {27'd0, compBits}, '0);
    rdBoth("R2 reset value");
    chk(cpuRvalid == 1'b1, "R11 read valid next cycle", {31'd0, cpuRvalid}, 32'd1);
    idle(1);
    chk(cpuRvalid == 1'b0, "R11 valid low without read", {31'd0, cpuRvalid}, '0);

    // R4 R5 R8: each source alone
    for (int i = 0; i < 10; i++) begin
      pulse(10'b1 << i, 1'b0);
      rdBoth($sformatf("R4 R5 event %0d sets bit", i));
      chk(compBits == mdlComp, "R7 companion copy", {27'd0, compBits}, {27'd0, mdlComp});
      chk(irqN == (bitOf(i) == 10), "R8 irq by source", {31'd0, irqN}, {31'd0, (bitOf(i) == 10)});
      clearAll();
      chk(irqN == 1'b1, "R8 irq released", {31'd0, irqN}, 32'd1);
    end

    // R6: DMA-owned read parity
    pulse(10'b01_0000_0000, 1'b1);
    rdBoth("R6 dma read parity keeps bit 9 clear");
    idle(1);
    chk(irqN == 1'b1, "R6 no irq from dma parity", {31'd0, irqN}, 32'd1);

    // R8: release timing
    pulse(10'b00_0100_0000, 1'b0);
    idle(1);
    chk(irqN == 1'b0, "R8 irq asserted", {31'd0, irqN}, '0);
    wr1c(4'h1, 32'h80);
    chk(irqN == 1'b0, "R8 irq still low at clear edge", {31'd0, irqN}, '0);
    idle(1);
    chk(irqN == 1'b1, "R8 irq high one cycle later", {31'd0, irqN}, 32'd1);

    // R3 and R1: lanes, zero data, reserved bits
    pulse(10'b10_0000_0001, 1'b0);
    wr1c(4'hf, 32'h0);
    rdBoth("R3 zero write keeps bits");
    wr1c(4'h1, '1);
    rdBoth("R3 only enabled lane clears");
    wr1c(4'hc, '1);
    rdBoth("R3 upper lanes clear nothing");
    wr1c(4'hf, 32'hffff_f960);
    rdBoth("R1 reserved writes ignored");
    clearAll();

    // R7: independent clears
    pulse(10'b00_0000_0100, 1'b0);
    drive('0, 1'b0, 5'b01000, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, "");
    chk(compBits == 5'd0, "R7 companion cleared alone", {27'd0, compBits}, '0);
    rdBoth("R7 status kept after companion clear");
    pulse(10'b00_0000_0100, 1'b0);
    wr1c(4'h1, 32'h8);
    chk(compBits == 5'b01000, "R7 companion kept after status clear", {27'd0, compBits}, 32'h8);
    rdBoth("R7 status cleared alone");
    clearAll();

    // R9: configuration writes change nothing
    pulse(10'b00_0001_0000, 1'b0);
    drive('0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, "");
    rdBoth("R9 cfg write has no effect");

    // R10: set beats same-cycle clear
    drive(10'b00_0010_0000, 1'b0, '0, 1'b1, 4'hf, '1, 1'b0, 1'b0, 1'b0, "");
    rdBoth("R10 set wins over clear");
    clearAll();
    rdBoth("R3 all clear");

    idle(3);
    chk(cpuQ.size() == 0 && cfgQ.size() == 0, "R11 all reads returned",
        cpuQ.size() + cfgQ.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule